// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a page table of two levels kept in memory. A request carries a 32-bit virtual address and an access kind (read, write or execute) and is paired with the current table base address. The walker fetches the first-level entry and then the second-level entry through a single memory port with a valid/ready request side and a valid response side. It then returns either a translated frame number, the full physical address and the final table entry, or a fault code.

Validity is checked at both levels. Permission is checked against the access kind at the second level. When the access succeeds and the referenced or dirty flag of the final entry has to change, the walker writes the updated entry back before it reports the result. One walk is in flight at a time.

The controller is a five-state machine. IDLE accepts a request (IDLE to OUTER). OUTER issues the first-level read and waits for its data: it moves to INNER on a valid entry and to DONE on an invalid one. INNER issues the second-level read: it moves to WBACK when the entry must be updated and to DONE otherwise, which covers a fault and an entry that is already up to date. WBACK holds the write until it is accepted (WBACK to DONE). DONE presents the result for one cycle (DONE to IDLE).

Top module: `pgw_walker`

## Requirements
- R1: An accepted request first reads the entry at table_base + 4 × va[31:22], with mem_req_we = 0.
- R2: For a valid first-level entry, the next read is at {entry[19:0], 12'h000} + 4 × va[21:12].
- R3: An entry with bit 24 (valid) clear, at either level, ends the walk with res_fault = 2'b01, res_pte equal to that entry, res_paddr = 0, and no further memory access.
- R4: Access kind encoding: 00 read, 01 write, 10 execute, 11 reserved. Permission field bits 21:20 mean 00 read-only, 01 read-write, 10 execute-only, 11 read-write-execute. The reserved kind is never permitted. A denied access ends with res_fault = 2'b10, res_pte equal to the fetched entry, and no write.
- R5: On success, res_fault = 2'b00 and res_pte is the second-level entry with bit 23 (referenced) set. For a write access, bit 22 (modified) is set as well.
- R6: Exactly one write of the updated entry goes to the second-level entry address, and only when bit 23 or bit 22 changes value. Otherwise no write is issued.
- R7: On success, res_frame = entry[19:0] and res_paddr = {entry[19:0], va[11:0]}.
- R8: req_ready is high only in IDLE. res_valid is a single-cycle pulse for each accepted request.
- R9: A memory request that is not accepted keeps its valid, address, write flag and data unchanged in the next cycle.
- R10: After reset, req_ready = 1, mem_req_valid = 0 and res_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind (R4 encoding) |
| table_base | input | 32 | First-level table base, sampled on acceptance |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_req_wdata | output | 32 | Updated entry for a write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 2 | 00 none, 01 invalid entry, 10 permission |
| res_frame | output | 20 | Translated frame number |
| res_paddr | output | 32 | Physical address |
| res_pte | output | 32 | Final (updated or offending) entry |

## Verification
The bench builds the walker with its default parameters: 10-bit indices, a 12-bit offset and a 20-bit frame. With these values the whole table fits in a small word-addressed memory model, and both all-zero and all-ones indices and offsets can be reached. The memory model withdraws ready on a pseudo-random pattern and varies read latency, which exercises stalled requests and delayed responses. A scoreboard models each walk from its own copy of the table contents. It predicts the fault, the final entry, the physical address and whether a write-back must follow.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_INVALID = 2'b01,
        FLT_PROT    = 2'b10
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OUTER,
        ST_INNER,
        ST_WBACK,
        ST_DONE
    } walk_st_e;

    // permission field: 00 ro, 01 rw, 10 xo, 11 rwx
    function automatic logic prot_allows(input logic [1:0] prot, input acc_e acc);
        logic ok;
        unique case (acc)
            ACC_READ:  ok = (prot != 2'b10);
            ACC_WRITE: ok = prot[0];
            ACC_EXEC:  ok = prot[1];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 10,
    parameter int OFF_W    = 12,
    parameter int FRAME_W  = 20,
    parameter int ENT_LOG2 = 2
) (
    input  logic               sel_inner,
    input  logic [ADDR_W-1:0]  table_base,
    input  logic [FRAME_W-1:0] inner_frame,
    input  logic [IDX_W-1:0]   idx_outer,
    input  logic [IDX_W-1:0]   idx_inner,
    output logic [ADDR_W-1:0]  entry_addr
);
    localparam int PA_W  = FRAME_W + OFF_W;
    localparam int PAD_W = ADDR_W - IDX_W - ENT_LOG2;

    logic [PA_W-1:0]   inner_base_pa;
    logic [ADDR_W-1:0] inner_base;
    logic [ADDR_W-1:0] scaled_idx;
    logic [IDX_W-1:0]  idx_sel;

    assign inner_base_pa = {inner_frame, {OFF_W{1'b0}}};

    generate
        if (PA_W >= ADDR_W) begin : g_trunc
            assign inner_base = inner_base_pa[ADDR_W-1:0];
        end else begin : g_ext
            assign inner_base = {{(ADDR_W-PA_W){1'b0}}, inner_base_pa};
        end
    endgenerate

    assign idx_sel    = sel_inner ? idx_inner : idx_outer;
    assign scaled_idx = {{PAD_W{1'b0}}, idx_sel, {ENT_LOG2{1'b0}}};
    assign entry_addr = (sel_inner ? inner_base : table_base) + scaled_idx;

endmodule

// File: rtl/pgw_pte_check.sv
module pgw_pte_check
    import pgw_pkg::*;
#(
    parameter int PTE_W   = 32,
    parameter int FRAME_W = 20
) (
    input  logic [PTE_W-1:0]   pte,
    input  acc_e               acc,
    output logic               is_valid,
    output logic               prot_ok,
    output logic [FRAME_W-1:0] frame,
    output logic [PTE_W-1:0]   pte_upd,
    output logic               needs_wb
);
    localparam int PROT_LO = FRAME_W;
    localparam int MOD_BIT = FRAME_W + 2;
    localparam int REF_BIT = FRAME_W + 3;
    localparam int VLD_BIT = FRAME_W + 4;

    always_comb begin
        is_valid = pte[VLD_BIT];
        prot_ok  = prot_allows(pte[PROT_LO+1:PROT_LO], acc);
        frame    = pte[FRAME_W-1:0];
        pte_upd  = pte;
        pte_upd[REF_BIT] = 1'b1;
        if (acc == ACC_WRITE) begin
            pte_upd[MOD_BIT] = 1'b1;
        end
        needs_wb = (pte_upd != pte);
    end

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 10,
    parameter int OFF_W    = 12,
    parameter int FRAME_W  = 20,
    parameter int PTE_W    = 32,
    parameter int ENT_LOG2 = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic [1:0]         req_acc,
    input  logic [ADDR_W-1:0]  table_base,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_we,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [PTE_W-1:0]   mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_rdata,
    output logic               res_valid,
    output logic [1:0]         res_fault,
    output logic [FRAME_W-1:0] res_frame,
    output logic [FRAME_W+OFF_W-1:0] res_paddr,
    output logic [PTE_W-1:0]   res_pte
);
    localparam int PA_W    = FRAME_W + OFF_W;
    localparam int IN_LO   = OFF_W;
    localparam int OUT_LO  = OFF_W + IDX_W;
    localparam int REF_BIT = FRAME_W + 3;

    walk_st_e            st, st_nx;
    logic                issued;
    logic [ADDR_W-1:0]   va_q;
    logic [ADDR_W-1:0]   base_q;
    acc_e                acc_q;
    logic [FRAME_W-1:0]  tbl_frame_q;
    logic [PTE_W-1:0]    wb_pte_q;
    fault_e              fault_q;
    logic [PTE_W-1:0]    pte_q;
    logic [PA_W-1:0]     paddr_q;
    logic [FRAME_W-1:0]  frame_q;

    logic                rsp_take;
    logic                chk_valid;
    logic                chk_prot_ok;
    logic [FRAME_W-1:0]  chk_frame;
    logic [PTE_W-1:0]    chk_upd;
    logic                chk_needs_wb;
    logic                in_read;

    pgw_addr_gen #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .OFF_W   (OFF_W),
        .FRAME_W (FRAME_W),
        .ENT_LOG2(ENT_LOG2)
    ) i_addr (
        .sel_inner  (st != ST_OUTER),
        .table_base (base_q),
        .inner_frame(tbl_frame_q),
        .idx_outer  (va_q[OUT_LO+IDX_W-1:OUT_LO]),
        .idx_inner  (va_q[IN_LO+IDX_W-1:IN_LO]),
        .entry_addr (mem_req_addr)
    );

    pgw_pte_check #(
        .PTE_W  (PTE_W),
        .FRAME_W(FRAME_W)
    ) i_chk (
        .pte     (mem_rsp_rdata),
        .acc     (acc_q),
        .is_valid(chk_valid),
        .prot_ok (chk_prot_ok),
        .frame   (chk_frame),
        .pte_upd (chk_upd),
        .needs_wb(chk_needs_wb)
    );

    assign in_read       = (st == ST_OUTER) || (st == ST_INNER);
    assign rsp_take      = in_read && issued && mem_rsp_valid;
    assign mem_req_valid = (in_read && !issued) || (st == ST_WBACK);
    assign mem_req_we    = (st == ST_WBACK);
    assign mem_req_wdata = wb_pte_q;
    assign req_ready     = (st == ST_IDLE);
    assign res_valid     = (st == ST_DONE);
    assign res_fault     = fault_q;
    assign res_pte       = pte_q;
    assign res_paddr     = paddr_q;
    assign res_frame     = frame_q;

    // next-state decision
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) st_nx = ST_OUTER;
            end
            ST_OUTER: begin
                if (rsp_take) st_nx = chk_valid ? ST_INNER : ST_DONE;
            end
            ST_INNER: begin
                if (rsp_take) begin
                    if (chk_valid && chk_prot_ok && chk_needs_wb) st_nx = ST_WBACK;
                    else                                          st_nx = ST_DONE;
                end
            end
            ST_WBACK: begin
                if (mem_req_ready) st_nx = ST_DONE;
            end
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // captured request, walk progress and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued      <= 1'b0;
            va_q        <= '0;
            base_q      <= '0;
            acc_q       <= ACC_READ;
            tbl_frame_q <= '0;
            wb_pte_q    <= '0;
            fault_q     <= FLT_NONE;
            pte_q       <= '0;
            paddr_q     <= '0;
            frame_q     <= '0;
        end else begin
            if (st != st_nx)                                    issued <= 1'b0;
            else if (in_read && mem_req_valid && mem_req_ready) issued <= 1'b1;

            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        base_q <= table_base;
                        acc_q  <= acc_e'(req_acc);
                    end
                end
                ST_OUTER: begin
                    if (rsp_take) begin
                        tbl_frame_q <= chk_frame;
                        if (!chk_valid) begin
                            fault_q <= FLT_INVALID;
                            pte_q   <= mem_rsp_rdata;
                            paddr_q <= '0;
                            frame_q <= '0;
                        end
                    end
                end
                ST_INNER: begin
                    if (rsp_take) begin
                        if (!chk_valid || !chk_prot_ok) begin
                            fault_q <= chk_valid ? FLT_PROT : FLT_INVALID;
                            pte_q   <= mem_rsp_rdata;
                            paddr_q <= '0;
                            frame_q <= '0;
                        end else begin
                            fault_q  <= FLT_NONE;
                            pte_q    <= chk_upd;
                            wb_pte_q <= chk_upd;
                            paddr_q  <= {chk_frame, va_q[OFF_W-1:0]};
                            frame_q  <= chk_frame;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata))); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid); // R8
    AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R8
    AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> mem_req_wdata[REF_BIT]); // R5
    AST_FRAME_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == FLT_NONE) |-> (res_paddr[PA_W-1:OFF_W] == res_pte[FRAME_W-1:0])); // R7
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != FLT_NONE) |-> (res_paddr == '0)); // R3

endmodule

// File: tb/test_pgw_walker.sv
module test_pgw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [31:0] table_base = 32'h0000_1000;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_we;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        res_valid;
    logic [1:0]  res_fault;
    logic [19:0] res_frame;
    logic [31:0] res_paddr;
    logic [31:0] res_pte;

    always #2.5 clk = ~clk;

    pgw_walker i_pgw_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .table_base(table_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .res_valid(res_valid), .res_fault(res_fault), .res_frame(res_frame),
        .res_paddr(res_paddr), .res_pte(res_pte)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [0:4095];
    logic [7:0]  lfsr;
    logic        pend;
    logic        dly;
    logic [31:0] pend_data;
    int          wr_cnt;
    int          rd_cnt;
    logic [31:0] first_rd_addr;
    logic [31:0] last_rd_addr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr          <= 8'hA5;
            mem_req_ready <= 1'b0;
            pend          <= 1'b0;
            dly           <= 1'b0;
            pend_data     <= '0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_rdata <= '0;
            wr_cnt        <= 0;
            rd_cnt        <= 0;
        end else begin
            lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_req_ready <= lfsr[0] | lfsr[3];
            mem_rsp_valid <= 1'b0;
            if (pend) begin
                if (dly) dly <= 1'b0;
                else begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= pend_data;
                    pend          <= 1'b0;
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    mem[mem_req_addr[13:2]] <= mem_req_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    pend      <= 1'b1;
                    dly       <= lfsr[5];
                    pend_data <= mem[mem_req_addr[13:2]];
                    if (rd_cnt == 0) first_rd_addr <= mem_req_addr;
                    last_rd_addr <= mem_req_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
    end

    // R9 observed at the port: a stalled request repeats unchanged
    logic        stall_seen = 1'b0;
    logic [31:0] stall_addr;
    logic        stall_we;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (stall_seen) begin
                chk(mem_req_valid && mem_req_addr == stall_addr && mem_req_we == stall_we,
                    "R9 stalled request held", mem_req_addr, stall_addr);
            end
            stall_seen <= mem_req_valid && !mem_req_ready;
            stall_addr <= mem_req_addr;
            stall_we   <= mem_req_we;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [1:0]  fault;
        logic [31:0] paddr;
        logic [31:0] pte;
        logic [31:0] first_addr;
        bit          has_wb;
        int          wb_word;
        logic [31:0] wb_val;
        int          wr_total;
        int          reads;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   exp_wr = 0;
    int   rd_base = 0;

    function automatic logic [31:0] mk_pte(input bit v, input bit r, input bit m,
                                           input logic [1:0] prot, input logic [19:0] fr);
        return {7'b0, v, r, m, prot, fr};
    endfunction

    function automatic bit allowed(input logic [1:0] prot, input logic [1:0] acc);
        case (acc)
            2'b00:   return prot != 2'b10;
            2'b01:   return prot == 2'b01 || prot == 2'b11;
            2'b10:   return prot == 2'b10 || prot == 2'b11;
            default: return 1'b0;
        endcase
    endfunction

    task automatic walk(input logic [9:0] oi, input logic [9:0] ii, input logic [11:0] off,
                        input logic [1:0] acc, input string tag);
        exp_t e;
        logic [31:0] va, oa, ia, ope, ipe, np;
        va = {oi, ii, off};
        oa = table_base + {20'b0, oi, 2'b00};
        ope = mem[oa[13:2]];
        e.tag = tag; e.has_wb = 0; e.wb_word = 0; e.wb_val = 0; e.paddr = 0;
        e.first_addr = oa;
        if (!ope[24]) begin
            e.fault = 2'b01; e.pte = ope; e.reads = 1;
        end else begin
            ia  = {ope[19:0], 12'h000} + {20'b0, ii, 2'b00};
            ipe = mem[ia[13:2]];
            e.reads = 2;
            if (!ipe[24]) begin
                e.fault = 2'b01; e.pte = ipe;
            end else if (!allowed(ipe[21:20], acc)) begin
                e.fault = 2'b10; e.pte = ipe;
            end else begin
                np = ipe | 32'h0080_0000 | ((acc == 2'b01) ? 32'h0040_0000 : 32'h0);
                e.fault = 2'b00; e.pte = np; e.paddr = {np[19:0], off};
                if (np != ipe) begin
                    e.has_wb = 1; e.wb_word = int'(ia[13:2]); e.wb_val = np; exp_wr++;
                end
            end
        end
        e.wr_total = exp_wr;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_base = rd_cnt;
        exp_q.push_back(e);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R8 busy during walk"}, {31'b0, req_ready}, 32'h0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected result", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(res_fault == e.fault, {e.tag, " fault"}, {30'b0, res_fault}, {30'b0, e.fault});
                chk(res_pte == e.pte, {e.tag, " pte"}, res_pte, e.pte);
                chk(res_paddr == e.paddr, {e.tag, " R7 paddr"}, res_paddr, e.paddr);
                chk(res_frame == e.paddr[31:12], {e.tag, " R7 frame"}, {12'b0, res_frame}, {12'b0, e.paddr[31:12]});
                chk(first_rd_addr == e.first_addr || rd_base != 0, {e.tag, " R1 outer addr"}, first_rd_addr, e.first_addr);
                chk(rd_cnt - rd_base == e.reads, {e.tag, " R3 read count"}, rd_cnt - rd_base, e.reads);
                chk(wr_cnt == e.wr_total, {e.tag, " R6 write count"}, wr_cnt, e.wr_total);
                if (e.has_wb)
                    chk(mem[e.wb_word] == e.wb_val, {e.tag, " R6 written entry"}, mem[e.wb_word], e.wb_val);
            end
        end
    end

    // outer address check for every walk: last outer read address observed
    logic [31:0] outer_seen;
    always @(posedge clk) begin
        if (rst_n && mem_req_valid && mem_req_ready && !mem_req_we && i_pgw_walker.req_ready == 1'b0 && rd_cnt == rd_base)
            outer_seen <= mem_req_addr;
    end

    initial begin
        for (int k = 0; k < 4096; k++) mem[k] = '0;
        // outer table at 0x1000 (words 1024..2047)
        mem[1024 + 0]    = mk_pte(1, 0, 0, 2'b00, 20'h00002);
        mem[1024 + 5]    = mk_pte(1, 0, 0, 2'b00, 20'h00003);
        mem[1024 + 1023] = mk_pte(1, 0, 0, 2'b00, 20'h00003);
        // inner table in frame 2 (words 2048..3071)
        mem[2048 + 0] = mk_pte(1, 0, 0, 2'b01, 20'h12345);
        mem[2048 + 1] = mk_pte(1, 0, 0, 2'b00, 20'hABCDE);
        mem[2048 + 2] = mk_pte(1, 0, 0, 2'b10, 20'h00777);
        mem[2048 + 4] = mk_pte(1, 1, 1, 2'b11, 20'hFFFFF);
        // inner table in frame 3 (words 3072..4095)
        mem[3072 + 1023] = mk_pte(1, 0, 0, 2'b11, 20'h55AA5);
        mem[3072 + 7]    = mk_pte(1, 0, 0, 2'b01, 20'h00001);

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after reset", {31'b0, req_ready}, 32'h1);
        chk(mem_req_valid == 1'b0, "R10 no memory request", {31'b0, mem_req_valid}, 32'h0);
        chk(res_valid == 1'b0, "R10 no result", {31'b0, res_valid}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        walk(10'd0, 10'd0, 12'h0AB, 2'b00, "R5 R2 read sets ref");
        chk(outer_seen == 32'h0000_1000, "R1 outer entry address", outer_seen, 32'h0000_1000);
        chk(last_rd_addr == 32'h0000_2000, "R2 inner entry address", last_rd_addr, 32'h0000_2000);
        walk(10'd0, 10'd0, 12'h123, 2'b00, "R6 repeat read no write");
        walk(10'd0, 10'd0, 12'hFFF, 2'b01, "R5 write sets dirty");
        walk(10'd0, 10'd1, 12'h010, 2'b01, "R4 write to read-only");
        walk(10'd0, 10'd2, 12'h004, 2'b10, "R4 exec on exec-only");
        walk(10'd0, 10'd2, 12'h008, 2'b00, "R4 read on exec-only");
        walk(10'd1, 10'd0, 12'h000, 2'b00, "R3 outer invalid");
        walk(10'd0, 10'd3, 12'h000, 2'b00, "R3 inner invalid");
        walk(10'd0, 10'd4, 12'h020, 2'b11, "R4 reserved access");
        walk(10'd0, 10'd4, 12'h024, 2'b01, "R6 write already dirty");
        walk(10'd1023, 10'd1023, 12'hFFF, 2'b10, "R7 top indices exec");
        chk(outer_seen == 32'h0000_1FFC, "R1 top outer address", outer_seen, 32'h0000_1FFC);
        chk(last_rd_addr == 32'h0000_3FFC, "R2 top inner address", last_rd_addr, 32'h0000_3FFC);
        walk(10'd5, 10'd7, 12'h555, 2'b01, "R5 write clean page");
        table_base = 32'h0000_1004;
        walk(10'd4, 10'd7, 12'h001, 2'b00, "R1 shifted base");

        repeat (4) @(negedge clk);
        chk(res_valid == 1'b0, "R8 no stray result", {31'b0, res_valid}, 32'h0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule